// File: doc/BRIEF.md
# DAC Load and Format Controller

This block is the digital front end of a two-channel 12-bit voltage DAC. Each channel owns a bus-writable control register and a data register. A written code does not reach the analog core straight away: the block copies it into a per-channel output latch when a selected load event occurs. The load event can be the data write itself, the completion of writes to a group of linked channels, or a rising edge on one of two timer strobes.

On the way into the latch, the code is turned into offset binary. Straight-binary codes pass through unchanged. Two's-complement codes have their active top bit inverted. In 8-bit mode the byte is left-aligned inside the 12-bit core word.

Each latch load raises a per-channel flag. The interrupt-enable bit decides where the flag goes: to an interrupt line when it is set, or to a DMA request line when it is clear. A DMA acknowledge for the channel clears the flag.

Top module: `dac_load_ctrl`

## Requirements
- R1: With load select 0 (control bits 3:2 = 00) and enable set (control bit 0), a data write copies the converted code into that channel's latch on the same clock edge that stores the data.
- R2: With load select 1, a data write only marks the channel as written. Setting the group bit (control bit 1) on a channel links it to the next higher channel. When every linked channel in load-select-1 mode has been written, all of their latches load on the same edge and the marks clear. The group bit on the highest channel links nothing, so that channel loads on its own write.
- R3: With load select 2 or 3, the latch loads once for each rising edge of `strobe_a` or `strobe_b` respectively. The load occurs within three clocks of the edge. Holding a strobe high and the other strobe's edges cause no load.
- R4: Conversion uses the format bit (control bit 5: 0 straight, 1 two's complement) and the resolution bit (control bit 4: 0 = 12-bit, 1 = 8-bit).
  - 12-bit mode: the core code is data[11:0], with bit 11 inverted in two's complement.
  - 8-bit mode: the core code is {data[7:0], 4'b0000}, with bit 7 of the data inverted in two's complement.
- R5: While enable is 0, data writes update the data register but the latch keeps its value.
- R6: Reading the data register (`rd_ctl` = 0) returns the stored 12 bits with bits 15:12 zero. Reading the control register returns its 8 bits in bits 7:0.
- R7: The channel flag (control bit 7) is set on the edge where its latch loads. `irq` equals flag AND interrupt-enable (control bit 6). `dma_req` equals flag AND NOT interrupt-enable.
- R8: A pulse on `dma_ack` for a channel clears its flag, unless the latch loads in the same cycle. A control write stores bit 7 as the new flag value.
- R9: After reset, all registers, latches, flags and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 1 | Channel selected by the write |
| wr_ctl | input | 1 | 1 writes the control register, 0 writes the data register |
| wr_data | input | 16 | Write data |
| rd_ch | input | 1 | Channel selected for readback |
| rd_ctl | input | 1 | 1 reads the control register, 0 reads the data register |
| rd_data | output | 16 | Readback value |
| strobe_a | input | 1 | Asynchronous timer strobe A |
| strobe_b | input | 1 | Asynchronous timer strobe B |
| dma_ack | input | 2 | Per-channel DMA transfer start; clears the flag |
| core_code | output | 24 | Offset-binary latch contents, channel c in bits 12c+11:12c |
| irq | output | 2 | Per-channel interrupt request |
| dma_req | output | 2 | Per-channel DMA request |

## Verification
A wrong load decision shows at `core_code` on the edge that should have loaded the latch, or on an edge that should not have. Immediate and grouped loads are therefore checked one clock after the write. Strobe loads are checked a few clocks after the strobe edge, because the strobes pass through synchronizers. A corrupted flag or written mark shows on `irq` or `dma_req` in the same cycle. A stale grouped mark shows as a latch that loads one write too early. Conversion faults show as a wrong top bit or non-zero low nibble in the first loaded code.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    localparam int CTL_W = 8;

    typedef enum logic [1:0] {
        LD_WRITE  = 2'd0,
        LD_GROUP  = 2'd1,
        LD_STRB_A = 2'd2,
        LD_STRB_B = 2'd3
    } lsel_e;

    // Control register, MSB first: bit 7 flag ... bit 0 enable
    typedef struct packed {
        logic  flag;
        logic  ie;
        logic  fmt;
        logic  res;
        lsel_e lsel;
        logic  grp;
        logic  en;
    } ctl_t;

endpackage

// File: rtl/dlc_strobe_sync.sv
module dlc_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.s2 & ~sync_q.s3;

    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/dlc_code_fmt.sv
module dlc_code_fmt #(
    parameter int DATA_W = 12,
    parameter int LOW_W  = 8
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic              res_i,
    input  logic              fmt_i,
    output logic [DATA_W-1:0] code_o
);
    localparam int PAD_W = DATA_W - LOW_W;

    logic [DATA_W-1:0] full_code;
    logic [LOW_W-1:0]  low_code;

    always_comb begin
        full_code = raw_i;
        full_code[DATA_W-1] = raw_i[DATA_W-1] ^ fmt_i;
        low_code = raw_i[LOW_W-1:0];
        low_code[LOW_W-1] = raw_i[LOW_W-1] ^ fmt_i;
        code_o = res_i ? {low_code, {PAD_W{1'b0}}} : full_code;
    end

endmodule

// File: rtl/dlc_group_eval.sv
module dlc_group_eval #(
    parameter int N_CH = 2
) (
    input  logic [N_CH-1:0] grp_i,
    input  logic [N_CH-1:0] mode_i,
    input  logic [N_CH-1:0] written_i,
    output logic [N_CH-1:0] fire_o
);
    localparam int ID_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    // First channel of the chain holding channel c; the top group bit is never used
    function automatic logic [ID_W-1:0] chain_id(input logic [N_CH-1:0] g, input int c);
        logic [ID_W-1:0] r;
        r = '0;
        for (int k = 0; k < N_CH - 1; k++) begin
            if (k < c && !g[k]) r = ID_W'(k + 1);
        end
        return r;
    endfunction

    always_comb begin
        for (int c = 0; c < N_CH; c++) begin
            fire_o[c] = mode_i[c] & written_i[c];
            for (int k = 0; k < N_CH; k++) begin
                if (chain_id(grp_i, k) == chain_id(grp_i, c) && mode_i[k] && !written_i[k])
                    fire_o[c] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
    import dlc_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int DATA_W = 12,
    parameter int LOW_W  = 8,
    parameter int BUS_W  = 16,
    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [CH_W-1:0]        wr_ch,
    input  logic                   wr_ctl,
    input  logic [BUS_W-1:0]       wr_data,
    input  logic [CH_W-1:0]        rd_ch,
    input  logic                   rd_ctl,
    output logic [BUS_W-1:0]       rd_data,
    input  logic                   strobe_a,
    input  logic                   strobe_b,
    input  logic [N_CH-1:0]        dma_ack,
    output logic [N_CH*DATA_W-1:0] core_code,
    output logic [N_CH-1:0]        irq,
    output logic [N_CH-1:0]        dma_req
);
    typedef struct packed {
        ctl_t [N_CH-1:0]              ctl;
        logic [N_CH-1:0][DATA_W-1:0]  data;
        logic [N_CH-1:0][DATA_W-1:0]  latch;
        logic [N_CH-1:0]              wflag;
    } state_t;

    state_t st_d, st_q;

    logic                        pulse_a, pulse_b;
    logic [N_CH-1:0]             dhit, chit, ld, fire;
    logic [N_CH-1:0]             grp_vec, grp_mode, wr_now;
    logic [N_CH-1:0][DATA_W-1:0] raw, code;

    dlc_strobe_sync i_sync_a (.clk(clk), .rst_n(rst_n), .async_i(strobe_a), .rise_o(pulse_a));
    dlc_strobe_sync i_sync_b (.clk(clk), .rst_n(rst_n), .async_i(strobe_b), .rise_o(pulse_b));

    dlc_group_eval #(.N_CH(N_CH)) i_group (
        .grp_i     (grp_vec),
        .mode_i    (grp_mode),
        .written_i (wr_now),
        .fire_o    (fire)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign dhit[c]     = wr_en && !wr_ctl && (wr_ch == CH_W'(c));
        assign chit[c]     = wr_en &&  wr_ctl && (wr_ch == CH_W'(c));
        assign raw[c]      = dhit[c] ? wr_data[DATA_W-1:0] : st_q.data[c];
        assign grp_vec[c]  = st_q.ctl[c].grp;
        assign grp_mode[c] = (st_q.ctl[c].lsel == LD_GROUP);
        assign wr_now[c]   = st_q.wflag[c] | dhit[c];
        assign ld[c] = st_q.ctl[c].en &&
                       (((st_q.ctl[c].lsel == LD_WRITE)  && dhit[c]) ||
                        fire[c] ||
                        ((st_q.ctl[c].lsel == LD_STRB_A) && pulse_a) ||
                        ((st_q.ctl[c].lsel == LD_STRB_B) && pulse_b));

        dlc_code_fmt #(.DATA_W(DATA_W), .LOW_W(LOW_W)) i_fmt (
            .raw_i  (raw[c]),
            .res_i  (st_q.ctl[c].res),
            .fmt_i  (st_q.ctl[c].fmt),
            .code_o (code[c])
        );

        assign core_code[c*DATA_W +: DATA_W] = st_q.latch[c];
        assign irq[c]     = st_q.ctl[c].flag &  st_q.ctl[c].ie;
        assign dma_req[c] = st_q.ctl[c].flag & ~st_q.ctl[c].ie;

        // R5
        latch_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.latch[c] != $past(st_q.latch[c])) |-> $past(st_q.ctl[c].en));

        // R4
        low_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ld[c] && st_q.ctl[c].res) |=> (core_code[c*DATA_W +: DATA_W-LOW_W] == '0));

        // R8
        flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dma_ack[c] && !ld[c] && !wr_en) |=> (!irq[c] && !dma_req[c]));
    end

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < N_CH; c++) begin
            if (chit[c]) st_d.ctl[c] = ctl_t'(wr_data[CTL_W-1:0]);
            if (dhit[c]) st_d.data[c] = wr_data[DATA_W-1:0];
            if (fire[c])
                st_d.wflag[c] = 1'b0;
            else if (dhit[c] && grp_mode[c])
                st_d.wflag[c] = 1'b1;
            if (dma_ack[c]) st_d.ctl[c].flag = 1'b0;
            if (ld[c]) begin
                st_d.latch[c]    = code[c];
                st_d.ctl[c].flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (rd_ctl) rd_data = BUS_W'(st_q.ctl[rd_ch]);
        else        rd_data = BUS_W'(st_q.data[rd_ch]);
    end

endmodule

// File: tb/test_dac_load_ctrl.sv
module test_dac_load_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_ch = '0;
    logic        wr_ctl = 1'b0;
    logic [15:0] wr_data = '0;
    logic [0:0]  rd_ch = '0;
    logic        rd_ctl = 1'b0;
    logic [15:0] rd_data;
    logic        strobe_a = 1'b0;
    logic        strobe_b = 1'b0;
    logic [1:0]  dma_ack = '0;
    logic [23:0] core_code;
    logic [1:0]  irq, dma_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_load_ctrl i_dac_load_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_ctl(wr_ctl),
        .wr_data(wr_data), .rd_ch(rd_ch), .rd_ctl(rd_ctl), .rd_data(rd_data),
        .strobe_a(strobe_a), .strobe_b(strobe_b), .dma_ack(dma_ack),
        .core_code(core_code), .irq(irq), .dma_req(dma_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] code_of(input int c);
        return core_code[c*12 +: 12];
    endfunction

    task automatic bus_write(input int ch, input bit is_ctl, input logic [15:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 1'(ch); wr_ctl = is_ctl; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack(input int ch);
        @(negedge clk);
        dma_ack[ch] = 1'b1;
        @(negedge clk);
        dma_ack = '0;
    endtask

    task automatic read_reg(input int ch, input bit is_ctl, output logic [15:0] val);
        rd_ch = 1'(ch); rd_ctl = is_ctl;
        #1;
        val = rd_data;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R9 codes", core_code, 0);
        check("R9 irq", irq, 0);
        check("R9 dma_req", dma_req, 0);
        read_reg(0, 1, v);
        check("R9 ctl0 read", v, 0);
    endtask

    task automatic t_immediate();
        logic [15:0] v;
        bus_write(0, 1, 16'h0001);
        bus_write(0, 0, 16'hFABC);
        check("R1 immediate load", code_of(0), 12'hABC);
        check("R7 dma_req when ie=0", dma_req[0], 1);
        check("R7 irq when ie=0", irq[0], 0);
        read_reg(0, 0, v);
        check("R6 data read top nibble zero", v, 16'h0ABC);
        read_reg(0, 1, v);
        check("R6 ctl read with flag", v, 16'h0081);
    endtask

    task automatic t_format();
        bus_write(0, 1, 16'h0021);
        bus_write(0, 0, 16'h0123);
        check("R4 12-bit twos positive", code_of(0), 12'h923);
        bus_write(0, 0, 16'h0800);
        check("R4 12-bit twos most negative", code_of(0), 12'h000);
        bus_write(0, 1, 16'h0031);
        bus_write(0, 0, 16'h00F5);
        check("R4 8-bit twos", code_of(0), 12'h750);
        bus_write(0, 1, 16'h0011);
        bus_write(0, 0, 16'h0FA5);
        check("R4 8-bit straight", code_of(0), 12'hA50);
    endtask

    task automatic t_enable();
        logic [15:0] v;
        bus_write(1, 1, 16'h0000);
        bus_write(1, 0, 16'h0555);
        check("R5 latch held while disabled", code_of(1), 12'h000);
        check("R5 no flag while disabled", dma_req[1], 0);
        read_reg(1, 0, v);
        check("R5 data register updated", v, 16'h0555);
    endtask

    task automatic t_flag();
        logic [15:0] v;
        bus_write(0, 1, 16'h0041);
        check("R8 ctl write clears flag", irq[0], 0);
        bus_write(0, 0, 16'h0321);
        check("R7 irq when ie=1", irq[0], 1);
        check("R7 no dma_req when ie=1", dma_req[0], 0);
        ack(0);
        check("R8 ack clears irq", irq[0], 0);
        read_reg(0, 1, v);
        check("R8 ctl after ack", v, 16'h0041);
        bus_write(0, 1, 16'h0001);
        bus_write(0, 0, 16'h0322);
        check("R7 dma_req raised", dma_req[0], 1);
        ack(0);
        check("R8 ack clears dma_req", dma_req[0], 0);
        bus_write(0, 1, 16'h00C1);
        check("R8 ctl write sets flag", irq[0], 1);
        ack(0);
    endtask

    task automatic t_group();
        bus_write(0, 1, 16'h0007);
        bus_write(1, 1, 16'h0005);
        bus_write(0, 0, 16'h0111);
        check("R2 first write holds ch0", code_of(0), 12'h322);
        check("R2 first write holds ch1", code_of(1), 12'h000);
        bus_write(1, 0, 16'h0222);
        check("R2 group load ch0", code_of(0), 12'h111);
        check("R2 group load ch1", code_of(1), 12'h222);
        check("R7 both flags", dma_req, 2'b11);
        bus_write(1, 0, 16'h0333);
        check("R2 reverse order holds", code_of(1), 12'h222);
        bus_write(0, 0, 16'h0444);
        check("R2 reverse group ch0", code_of(0), 12'h444);
        check("R2 reverse group ch1", code_of(1), 12'h333);
    endtask

    task automatic t_group_top();
        bus_write(0, 1, 16'h0005);
        bus_write(1, 1, 16'h0007);
        bus_write(1, 0, 16'h0666);
        check("R2 top group bit ignored ch1", code_of(1), 12'h666);
        check("R2 top group bit ch0 untouched", code_of(0), 12'h444);
        bus_write(0, 0, 16'h0777);
        check("R2 unlinked ch0 loads alone", code_of(0), 12'h777);
    endtask

    task automatic t_strobe();
        bus_write(0, 1, 16'h0009);
        bus_write(1, 1, 16'h000D);
        bus_write(0, 0, 16'h00AA);
        bus_write(1, 0, 16'h00BB);
        check("R3 write alone no load ch0", code_of(0), 12'h777);
        check("R3 write alone no load ch1", code_of(1), 12'h666);
        strobe_a = 1'b1;
        wait_cycles(5);
        check("R3 strobe A loads ch0", code_of(0), 12'h0AA);
        check("R3 strobe A ignored by ch1", code_of(1), 12'h666);
        bus_write(0, 0, 16'h00CC);
        wait_cycles(5);
        check("R3 held strobe no reload", code_of(0), 12'h0AA);
        strobe_a = 1'b0;
        strobe_b = 1'b1;
        wait_cycles(5);
        check("R3 strobe B loads ch1", code_of(1), 12'h0BB);
        check("R3 strobe B ignored by ch0", code_of(0), 12'h0AA);
        strobe_a = 1'b1;
        wait_cycles(5);
        check("R3 new strobe A edge", code_of(0), 12'h0CC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_immediate();
        t_format();
        t_enable();
        t_flag();
        t_group();
        t_group_top();
        t_strobe();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule